// File: doc/BRIEF.md
# Single-Cycle Byte Processor

This block is a small processor core that finishes every instruction in one clock cycle. Each instruction is one byte. The core holds four 8-bit general registers, an 8-bit program counter and two condition flags: a zero flag and a negative flag. It holds no memory of its own. It fetches from a read-only instruction store and reaches a separate data store through its own address, write-data and read-data ports. Both stores are read combinationally, so an instruction and its data access fit within one cycle.

All state changes on the falling clock edge: the program counter, the registers, the flags and data-store writes. Reset is synchronous and active high. Register reads, decoding, the ALU, the immediate extenders and the next-address adder are combinational between falling edges. The instruction set has ten operations: register load and store, three register-to-register arithmetic and logic operations, an OR-with-immediate that always targets register 1, an immediate shift, and three conditional relative branches.

Top module: `byte_cpu_core`

## Requirements
- R1: While reset is high, each falling edge loads the program counter with 0x80 and clears all four registers and both flags. No data-store write strobe is raised while reset is high.
- R2: The operation is chosen by instruction bits 3..0. The codes 0001, 1010, 1100 and 1110 are undefined. An undefined code changes no register, no flag and no memory, and only advances the program counter.
- R3: Code 0000 loads the data word at address rB into rA. Code 0010 writes rA to the data store at address rB. rA is selected by bits 7..6 and rB by bits 5..4. Neither code changes a flag, and the read and write strobes are never high together.
- R4: Codes 0100, 0110 and 1000 write rA+rB, rA-rB and the bitwise NAND of rA and rB into rA. Each sets the zero flag when the 8-bit result is 0 and copies result bit 7 into the negative flag.
- R5: Any code matching x111 ORs register 1 with bits 7..3 zero-extended to 8 bits, writes the result into register 1 and updates both flags from it.
- R6: Any code matching x011 shifts rA (bits 7..6) by the 2-bit amount in bits 4..3. The shift is left when bit 5 is 1 and a zero-fill right shift when bit 5 is 0. The result goes back into rA and updates both flags.
- R7: Codes 0101, 1001 and 1101 branch when the zero flag is set, when the zero flag is clear, and when the negative flag is clear. A taken branch moves the program counter to PC+1 plus bits 7..4 sign-extended. A branch that is not taken moves it to PC+1.
- R8: Every instruction that is not a branch moves the program counter to PC+1. The program counter drives the instruction address port directly.
- R9: The program counter, registers and flags keep their values across the rising edge and change only on the falling edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on its falling edge |
| rst | input | 1 | Synchronous active-high reset |
| imem_addr | output | 8 | Instruction address, equal to the program counter |
| imem_data | input | 8 | Instruction byte read from the instruction store |
| dmem_addr | output | 8 | Data-store address, taken from rB |
| dmem_wdata | output | 8 | Data to be written, taken from rA |
| dmem_rdata | input | 8 | Word read from the data store at dmem_addr |
| dmem_we | output | 1 | Data-store write strobe for the coming falling edge |
| dmem_re | output | 1 | Data-store read strobe, raised for loads |

## Verification
The assertions are checked on every falling edge. They cover the reset address, the quiet write strobe during reset, the exclusive read and write strobes, the flags holding across loads and stores, and the next-address rule for taken branches, untaken branches and all other instructions. Register contents, ALU results, the OR-immediate target, the shift direction and the effect of undefined codes cannot be seen from the ports within one cycle. The bench shows them instead with short programs that store results into its data array. The same holds for loops that run through several backward branches.

// File: rtl/cpu8_pkg.sv
package cpu8_pkg;
  localparam int XLEN    = 8;
  localparam int REG_CNT = 4;
  localparam int RIDX_W  = $clog2(REG_CNT);
  localparam int OPC_W   = 4;
  localparam int IMM5_W  = 5;
  localparam int IMM4_W  = 4;
  localparam int SHAMT_W = 2;

  typedef logic [XLEN-1:0]   word_t;
  typedef logic [RIDX_W-1:0] ridx_t;

  typedef enum logic [2:0] {
    ALU_ADD  = 3'b000,
    ALU_SUB  = 3'b001,
    ALU_OR   = 3'b010,
    ALU_NAND = 3'b011,
    ALU_SHF  = 3'b100
  } alu_op_e;

  typedef enum logic [1:0] {
    BR_NONE,
    BR_ZSET,
    BR_ZCLR,
    BR_NCLR
  } br_cond_e;

  typedef struct packed {
    logic     rf_we;
    logic     wb_mem;
    logic     flags_we;
    logic     mem_rd;
    logic     mem_wr;
    logic     use_r1;
    logic     b_imm;
    alu_op_e  alu_op;
    br_cond_e br;
  } ctrl_t;

  localparam ridx_t IMPLICIT_REG = ridx_t'(1);
endpackage

// File: rtl/cpu8_decoder.sv
module cpu8_decoder
  import cpu8_pkg::*;
(
  input  logic [OPC_W-1:0] opc,
  output ctrl_t            ctrl
);
  always_comb begin
    ctrl        = '0;
    ctrl.alu_op = ALU_ADD;
    ctrl.br     = BR_NONE;
    casez (opc)
      4'b0000: begin
        ctrl.rf_we  = 1'b1;
        ctrl.wb_mem = 1'b1;
        ctrl.mem_rd = 1'b1;
      end
      4'b0010: ctrl.mem_wr = 1'b1;
      4'b0100: begin
        ctrl.rf_we    = 1'b1;
        ctrl.flags_we = 1'b1;
        ctrl.alu_op   = ALU_ADD;
      end
      4'b0110: begin
        ctrl.rf_we    = 1'b1;
        ctrl.flags_we = 1'b1;
        ctrl.alu_op   = ALU_SUB;
      end
      4'b1000: begin
        ctrl.rf_we    = 1'b1;
        ctrl.flags_we = 1'b1;
        ctrl.alu_op   = ALU_NAND;
      end
      4'b?111: begin
        ctrl.rf_we    = 1'b1;
        ctrl.flags_we = 1'b1;
        ctrl.use_r1   = 1'b1;
        ctrl.b_imm    = 1'b1;
        ctrl.alu_op   = ALU_OR;
      end
      4'b?011: begin
        ctrl.rf_we    = 1'b1;
        ctrl.flags_we = 1'b1;
        ctrl.alu_op   = ALU_SHF;
      end
      4'b0101: ctrl.br = BR_ZSET;
      4'b1001: ctrl.br = BR_ZCLR;
      4'b1101: ctrl.br = BR_NCLR;
      default: ;
    endcase
  end
endmodule

// File: rtl/cpu8_immgen.sv
module cpu8_immgen
  import cpu8_pkg::*;
(
  input  logic [IMM5_W-1:0]  fld,
  output word_t              imm5_zx,
  output word_t              br_off,
  output logic [SHAMT_W-1:0] shamt,
  output logic               shl
);
  assign imm5_zx = {{(XLEN-IMM5_W){1'b0}}, fld};
  assign br_off  = {{(XLEN-IMM4_W){fld[IMM5_W-1]}}, fld[IMM5_W-1 -: IMM4_W]};
  assign shamt   = fld[SHAMT_W-1:0];
  assign shl     = fld[SHAMT_W];
endmodule

// File: rtl/cpu8_regfile.sv
module cpu8_regfile
  import cpu8_pkg::*;
#(
  parameter int N = REG_CNT,
  parameter int W = XLEN,
  localparam int IW = $clog2(N)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          we,
  input  logic [IW-1:0] waddr,
  input  logic [W-1:0]  wdata,
  input  logic [IW-1:0] ra,
  input  logic [IW-1:0] rb,
  output logic [W-1:0]  qa,
  output logic [W-1:0]  qb
);
  logic [W-1:0] regs [N];
  logic [N-1:0] wsel;

  for (genvar g = 0; g < N; g++) begin : g_wsel
    assign wsel[g] = we && (waddr == IW'(g));
  end

  always_ff @(negedge clk) begin
    for (int i = 0; i < N; i++) begin
      if (rst) regs[i] <= '0;
      else if (wsel[i]) regs[i] <= wdata;
    end
  end

  assign qa = regs[ra];
  assign qb = regs[rb];
endmodule

// File: rtl/cpu8_alu.sv
module cpu8_alu
  import cpu8_pkg::*;
#(
  parameter int W  = XLEN,
  parameter int SW = SHAMT_W
) (
  input  logic [W-1:0]  a,
  input  logic [W-1:0]  b,
  input  alu_op_e       op,
  input  logic [SW-1:0] shamt,
  input  logic          shl,
  output logic [W-1:0]  y,
  output logic          z,
  output logic          n
);
  always_comb begin
    unique case (op)
      ALU_ADD:  y = a + b;
      ALU_SUB:  y = a - b;
      ALU_OR:   y = a | b;
      ALU_NAND: y = ~(a & b);
      ALU_SHF:  y = shl ? (a << shamt) : (a >> shamt);
      default:  y = a;
    endcase
  end

  assign z = (y == '0);
  assign n = y[W-1];
endmodule

// File: rtl/cpu8_nextpc.sv
module cpu8_nextpc
  import cpu8_pkg::*;
(
  input  word_t    pc,
  input  br_cond_e br,
  input  logic     z,
  input  logic     n,
  input  word_t    off,
  output word_t    pc_nxt
);
  word_t seq;
  logic  taken;

  assign seq = pc + word_t'(1);

  always_comb begin
    unique case (br)
      BR_ZSET: taken = z;
      BR_ZCLR: taken = !z;
      BR_NCLR: taken = !n;
      default: taken = 1'b0;
    endcase
  end

  assign pc_nxt = taken ? (seq + off) : seq;
endmodule

// File: rtl/byte_cpu_core.sv
module byte_cpu_core
  import cpu8_pkg::*;
#(
  parameter logic [XLEN-1:0] RESET_PC = 8'h80
) (
  input  logic            clk,
  input  logic            rst,
  output logic [XLEN-1:0] imem_addr,
  input  logic [XLEN-1:0] imem_data,
  output logic [XLEN-1:0] dmem_addr,
  output logic [XLEN-1:0] dmem_wdata,
  input  logic [XLEN-1:0] dmem_rdata,
  output logic            dmem_we,
  output logic            dmem_re
);
  word_t pc;
  word_t pc_nxt;
  logic  flag_z;
  logic  flag_n;
  ctrl_t ctrl;

  word_t              imm5_zx;
  word_t              br_off;
  logic [SHAMT_W-1:0] shamt;
  logic               shl;

  ridx_t idx_a;
  ridx_t idx_b;
  word_t val_a;
  word_t val_b;
  word_t alu_b;
  word_t alu_y;
  logic  alu_z;
  logic  alu_n;
  word_t wb_data;

  cpu8_decoder u_dec (
    .opc  (imem_data[OPC_W-1:0]),
    .ctrl (ctrl)
  );

  cpu8_immgen u_imm (
    .fld     (imem_data[XLEN-1 -: IMM5_W]),
    .imm5_zx (imm5_zx),
    .br_off  (br_off),
    .shamt   (shamt),
    .shl     (shl)
  );

  assign idx_a = ctrl.use_r1 ? IMPLICIT_REG : imem_data[XLEN-1 -: RIDX_W];
  assign idx_b = imem_data[XLEN-1-RIDX_W -: RIDX_W];

  cpu8_regfile #(.N(REG_CNT), .W(XLEN)) u_rf (
    .clk   (clk),
    .rst   (rst),
    .we    (ctrl.rf_we),
    .waddr (idx_a),
    .wdata (wb_data),
    .ra    (idx_a),
    .rb    (idx_b),
    .qa    (val_a),
    .qb    (val_b)
  );

  assign alu_b = ctrl.b_imm ? imm5_zx : val_b;

  cpu8_alu #(.W(XLEN), .SW(SHAMT_W)) u_alu (
    .a     (val_a),
    .b     (alu_b),
    .op    (ctrl.alu_op),
    .shamt (shamt),
    .shl   (shl),
    .y     (alu_y),
    .z     (alu_z),
    .n     (alu_n)
  );

  assign wb_data = ctrl.wb_mem ? dmem_rdata : alu_y;

  cpu8_nextpc u_npc (
    .pc     (pc),
    .br     (ctrl.br),
    .z      (flag_z),
    .n      (flag_n),
    .off    (br_off),
    .pc_nxt (pc_nxt)
  );

  always_ff @(negedge clk) begin
    if (rst) begin
      pc     <= RESET_PC;
      flag_z <= 1'b0;
      flag_n <= 1'b0;
    end else begin
      pc <= pc_nxt;
      if (ctrl.flags_we) begin
        flag_z <= alu_z;
        flag_n <= alu_n;
      end
    end
  end

  assign imem_addr  = pc;
  assign dmem_addr  = val_b;
  assign dmem_wdata = val_a;
  assign dmem_we    = ctrl.mem_wr && !rst;
  assign dmem_re    = ctrl.mem_rd && !rst;
endmodule

// File: rtl/cpu8_checker.sv
module cpu8_checker
  import cpu8_pkg::*;
#(
  parameter logic [XLEN-1:0] RESET_PC = 8'h80
) (
  input logic            clk,
  input logic            rst,
  input logic [XLEN-1:0] imem_addr,
  input logic [XLEN-1:0] imem_data,
  input logic            dmem_we,
  input logic            dmem_re,
  input logic            flag_z,
  input logic            flag_n
);
  logic [3:0] op;
  logic       is_br;
  logic       br_take;
  logic       is_mem;

  assign op      = imem_data[3:0];
  assign is_br   = (op == 4'b0101) || (op == 4'b1001) || (op == 4'b1101);
  assign br_take = ((op == 4'b0101) && flag_z) ||
                   ((op == 4'b1001) && !flag_z) ||
                   ((op == 4'b1101) && !flag_n);
  assign is_mem  = (op == 4'b0000) || (op == 4'b0010);

  // R1: reset loads the start address
  p_reset_pc_r1: assert property (@(negedge clk)
    rst |=> (imem_addr == RESET_PC));

  // R1: no write strobe while in reset
  p_quiet_reset_r1: assert property (@(negedge clk)
    rst |-> !dmem_we);

  // R3: read and write strobes never together
  p_rw_excl_r3: assert property (@(negedge clk) disable iff (rst)
    !(dmem_we && dmem_re));

  // R3: load and store leave the flags alone
  p_mem_flags_r3: assert property (@(negedge clk) disable iff (rst)
    is_mem |=> (flag_z == $past(flag_z)) && (flag_n == $past(flag_n)));

  // R3: store raises only the write strobe, load only the read strobe
  p_store_strobe_r3: assert property (@(negedge clk) disable iff (rst)
    (op == 4'b0010) |-> (dmem_we && !dmem_re));
  p_load_strobe_r3: assert property (@(negedge clk) disable iff (rst)
    (op == 4'b0000) |-> (dmem_re && !dmem_we));

  // R8: non-branch instructions step by one
  p_seq_pc_r8: assert property (@(negedge clk) disable iff (rst)
    !is_br |=> (imem_addr == $past(imem_addr) + 8'd1));

  // R7: taken branch adds the signed offset
  p_br_taken_r7: assert property (@(negedge clk) disable iff (rst)
    br_take |=> (imem_addr == $past(imem_addr) + 8'd1 +
                 {{4{$past(imem_data[7])}}, $past(imem_data[7:4])}));

  // R7: untaken branch steps by one
  p_br_fall_r7: assert property (@(negedge clk) disable iff (rst)
    (is_br && !br_take) |=> (imem_addr == $past(imem_addr) + 8'd1));
endmodule

bind byte_cpu_core cpu8_checker #(.RESET_PC(RESET_PC)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .imem_addr (imem_addr),
  .imem_data (imem_data),
  .dmem_we   (dmem_we),
  .dmem_re   (dmem_re),
  .flag_z    (flag_z),
  .flag_n    (flag_n)
);

// File: tb/test_byte_cpu_core.sv
`timescale 1ns/1ps
module test_byte_cpu_core;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [7:0] imem_addr, imem_data, dmem_addr, dmem_wdata, dmem_rdata;
  logic       dmem_we, dmem_re;

  logic [7:0] imem [256];
  logic [7:0] dmem [256];

  int total = 0;
  int bad   = 0;
  bit done  = 1'b0;

  always #10 clk = ~clk;  // 50 MHz

  byte_cpu_core i_byte_cpu_core (
    .clk(clk), .rst(rst),
    .imem_addr(imem_addr), .imem_data(imem_data),
    .dmem_addr(dmem_addr), .dmem_wdata(dmem_wdata), .dmem_rdata(dmem_rdata),
    .dmem_we(dmem_we), .dmem_re(dmem_re)
  );

  assign imem_data  = imem[imem_addr];
  assign dmem_rdata = dmem[dmem_addr];

  always @(negedge clk) if (dmem_we === 1'b1) dmem[dmem_addr] <= dmem_wdata;

  // {instr, a (data[0]), b (data[1]), expected data[1], requirement}
  // program: load r2,(r0); ori r1,1; load r3,(r1); <instr>; store r2,(r1)
  localparam int NVEC = 14;
  localparam logic [35:0] VEC [NVEC] = '{
    {8'hB4, 8'h12, 8'h34, 8'h46, 4'd4},  // R4 add
    {8'hB4, 8'hFF, 8'h01, 8'h00, 4'd4},  // R4 add wraps to zero
    {8'hB6, 8'h10, 8'h20, 8'hF0, 4'd4},  // R4 sub borrow
    {8'hB8, 8'hF0, 8'h3C, 8'hCF, 4'd4},  // R4 nand
    {8'hA4, 8'h21, 8'h00, 8'h42, 4'd4},  // R4 add same register
    {8'hB3, 8'h81, 8'h00, 8'h04, 4'd6},  // R6 left by 2
    {8'h9B, 8'h90, 8'h00, 8'h12, 4'd6},  // R6 right by 3
    {8'hA3, 8'h5A, 8'h00, 8'h5A, 4'd6},  // R6 left by 0
    {8'h8B, 8'h80, 8'h00, 8'h40, 4'd6},  // R6 right is zero fill
    {8'h8C, 8'h77, 8'h00, 8'h77, 4'd2},  // R2 undefined 1100
    {8'hAA, 8'h77, 8'h00, 8'h77, 4'd2},  // R2 undefined 1010
    {8'h8E, 8'h3B, 8'h00, 8'h3B, 4'd2},  // R2 undefined 1110
    {8'hB0, 8'h11, 8'h01, 8'h01, 4'd3},  // R3 load r2,(r3)
    {8'hE2, 8'h05, 8'h66, 8'h05, 4'd3}   // R3 store r3,(r2)
  };

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%02h exp=%02h", req, act, exp);
    end
  endtask

  task automatic clear_mem();
    for (int i = 0; i < 256; i++) begin
      dmem[i] <= 8'h00;
      imem[i] = 8'h01;
    end
  endtask

  task automatic hold_reset(input int cycles);
    rst = 1'b1;
    repeat (cycles) @(negedge clk);
    @(posedge clk);
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
    @(posedge clk);
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog R8 act=running exp=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    // vector table
    for (int v = 0; v < NVEC; v++) begin
      clear_mem();
      dmem[0] <= VEC[v][27:20];
      dmem[1] <= VEC[v][19:12];
      imem[8'h80] = 8'h80;
      imem[8'h81] = 8'h0F;
      imem[8'h82] = 8'hD0;
      imem[8'h83] = VEC[v][35:28];
      imem[8'h84] = 8'h92;
      hold_reset(2);
      rst = 1'b0;
      step(5);
      chk($sformatf("R%0d vec%0d", VEC[v][3:0], v), dmem[1], VEC[v][11:4]);
    end
    chk("R3 store target", dmem[5], 8'h66);

    // R1: reset state; store r3,(r0) waits at 0x80, old r3=0x66
    clear_mem();
    dmem[0] <= 8'hAA;
    imem[8'h80] = 8'hC2;
    hold_reset(3);
    chk("R1 pc after reset", imem_addr, 8'h80);
    chk("R1 no write in reset", dmem[0], 8'hAA);
    rst = 1'b0;
    step(1);
    chk("R1 regs cleared", dmem[0], 8'h00);

    // R7 bz taken after a load (R3 flags kept), then bz not taken
    clear_mem();
    dmem[0] <= 8'h05;
    imem[8'h80] = 8'h80;  // load r2,(r0)
    imem[8'h81] = 8'hA6;  // sub r2,r2 -> Z=1
    imem[8'h82] = 8'hC0;  // load r3,(r0)
    imem[8'h83] = 8'h15;  // bz +1
    imem[8'h84] = 8'hFF;  // ori 0x1F (skipped)
    imem[8'h85] = 8'h17;  // ori 2
    imem[8'h86] = 8'h52;  // store r1,(r1)
    imem[8'h87] = 8'h15;  // bz +1, Z=0
    imem[8'h88] = 8'h42;  // store r1,(r0)
    hold_reset(2);
    rst = 1'b0;
    step(8);
    chk("R7 bz taken", dmem[2], 8'h02);
    chk("R3 load keeps Z", dmem[8'h1F], 8'h00);
    chk("R7 bz not taken", dmem[0], 8'h02);
    chk("R8 pc after run", imem_addr, 8'h89);

    // R7 backward bnz loop, bpz both ways, R4 negative result
    clear_mem();
    dmem[0] <= 8'h03;
    dmem[1] <= 8'h01;
    imem[8'h80] = 8'h80;  // load r2,(r0)
    imem[8'h81] = 8'h0F;  // ori 1
    imem[8'h82] = 8'hD0;  // load r3,(r1)
    imem[8'h83] = 8'hB6;  // sub r2,r3
    imem[8'h84] = 8'hE9;  // bnz -2
    imem[8'h85] = 8'h82;  // store r2,(r0)
    imem[8'h86] = 8'hB6;  // sub r2,r3 -> 0xFF, N=1
    imem[8'h87] = 8'h1D;  // bpz +1, not taken
    imem[8'h88] = 8'h92;  // store r2,(r1)
    imem[8'h89] = 8'hB4;  // add r2,r3 -> 0, N=0
    imem[8'h8A] = 8'h1D;  // bpz +1, taken
    imem[8'h8B] = 8'hC2;  // store r3,(r0) (skipped)
    imem[8'h8C] = 8'h92;  // store r2,(r1)
    hold_reset(2);
    rst = 1'b0;
    step(10);
    chk("R7 bnz loop result", dmem[0], 8'h00);
    chk("R7 bnz loop exit pc", imem_addr, 8'h86);
    step(3);
    chk("R4 negative sub / R7 bpz fall", dmem[1], 8'hFF);
    step(3);
    chk("R7 bpz taken skip", dmem[0], 8'h00);
    chk("R4 add to zero", dmem[1], 8'h00);
    chk("R7 bpz target pc", imem_addr, 8'h8D);

    // R5 OR-immediate into r1, R9 falling-edge update
    clear_mem();
    imem[8'h80] = 8'h0F;  // ori 1
    imem[8'h81] = 8'hA7;  // ori 0x14 -> 0x15
    imem[8'h82] = 8'h52;  // store r1,(r1)
    imem[8'h83] = 8'hFF;  // ori 0x1F -> 0x1F
    imem[8'h84] = 8'h42;  // store r1,(r0)
    hold_reset(2);
    rst = 1'b0;
    #5;
    chk("R9 pc before falling edge", imem_addr, 8'h80);
    @(negedge clk);
    #1;
    chk("R9 pc after falling edge", imem_addr, 8'h81);
    step(4);
    chk("R5 ori merge", dmem[8'h15], 8'h15);
    chk("R5 ori full immediate", dmem[0], 8'h1F);

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule